// File: doc/BRIEF.md
# UTMI Link-Side Transmit Controller

This block drives the transmit half of a UTMI+ link-to-PHY connection. Upstream it accepts packet bytes from a valid/ready byte stream in which a marker flags the final byte of each packet. Toward the PHY it drives the data bus, the transmit-valid strobe and the three mode controls (operating mode, speed select, termination select), and it watches the PHY's transmit-ready acknowledge. The PHY adds SYNC, EOP, bit stuffing and line coding. This block only decides when a packet opens and closes and which byte sits on the bus.

A packet opens when the first byte is loaded and transmit-valid rises. Each edge where transmit-valid and transmit-ready are both high consumes the byte on the bus. The next byte is loaded at that same edge, so the PHY is never left without data. Transmit-valid drops on the edge after the final byte is taken. If the upstream stream runs dry in the middle of a packet, transmit-valid drops as well and a one-cycle underrun flag is raised.

Mode-change requests are stored and applied only while the bus is idle, never on an edge where transmit-valid moves. A request for the reserved operating-mode code is discarded. After reset is released, a start-up counter holds off the first packet.

Top module: `utmi_tx_link`

## Requirements
- R1: While reset is high, `utmi_txvalid`, `tx_underrun` and `s_ready` are 0. The mode outputs take their parameter reset values; by default operating mode 2'b00 (normal), speed 2'b01 (full speed) and termination 1.
- R2: After reset is released, `utmi_txvalid` stays low for the first START_WAIT (default 5) rising edges. If a byte is waiting, it rises on edge START_WAIT+1.
- R3: When a packet opens, the first stream byte is on `utmi_data` as `utmi_txvalid` rises. The bytes the PHY accepts match the stream bytes, in order.
- R4: While `utmi_txvalid` is high and `utmi_txready` is low, at the next edge `utmi_txvalid` stays high and `utmi_data` is unchanged.
- R5: When the PHY accepts a byte that is not the last, `s_ready` is high in that same cycle. The next stream byte is on `utmi_data` after that edge, with `utmi_txvalid` still high.
- R6: `utmi_txvalid` is low on the edge right after the PHY accepts a byte whose `s_last` was 1.
- R7: Between two packets, `utmi_txvalid` stays low for at least one full cycle.
- R8: `utmi_opmode`, `utmi_xcvrsel` and `utmi_termsel` never change on an edge where `utmi_txvalid` changes. They also never change while `utmi_txvalid` is high.
- R9: A mode request (a `mode_req_valid` pulse) made while the bus is idle is applied within three cycles. A request made during a packet is held and applied after the packet ends. Operating-mode codes: 00 normal, 01 non-driving, 10 coding disabled, 11 reserved. Speed codes: 00 high, 01 full, 10 low, 11 low-speed data with full-speed edges.
- R10: A request that carries operating mode 2'b11 is discarded: all three mode outputs keep their values.
- R11: If the stream has no valid byte when the PHY accepts a non-last byte, `utmi_txvalid` drops at that edge and `tx_underrun` is high for exactly one cycle.
- R12: While `utmi_txvalid` is low and no stream byte is offered, `utmi_txready` has no effect: no packet opens and nothing is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; every output is registered on its rising edge |
| rst | input | 1 | Active-high reset; asserted asynchronously, released synchronously |
| s_data | input | DATA_W | Stream byte |
| s_valid | input | 1 | Stream byte is valid |
| s_last | input | 1 | Stream byte is the final byte of its packet |
| s_ready | output | 1 | Byte is taken at this edge when `s_valid` is also high |
| mode_req_valid | input | 1 | One-cycle strobe that requests new mode settings |
| mode_req_opmode | input | 2 | Requested operating mode |
| mode_req_speed | input | 2 | Requested speed select |
| mode_req_term | input | 1 | Requested termination select |
| utmi_data | output | DATA_W | Transmit data bus to the PHY |
| utmi_txvalid | output | 1 | Packet in progress; rise opens and fall closes the packet |
| utmi_txready | input | 1 | PHY has taken the current byte at this edge |
| utmi_opmode | output | 2 | Operating mode to the PHY |
| utmi_xcvrsel | output | 2 | Speed select to the PHY |
| utmi_termsel | output | 1 | Termination select to the PHY |
| tx_underrun | output | 1 | One-cycle flag: the stream ran dry in the middle of a packet |

## Verification
The hardest condition to reach is a mode request that lands in the middle of a packet. It must be held until the bus is idle, and must then not land on the edge where transmit-valid falls. The bench throttles the PHY acknowledge to one edge in three, so the packet lasts long enough to issue the request while transmit-valid is high. A monitor compares every edge of the mode outputs with every edge of transmit-valid. The underrun case is reached with a source model that withholds one chosen byte index while the acknowledge stays high.

// File: rtl/utmi_tx_pkg.sv
package utmi_tx_pkg;

   typedef enum logic [1:0] {
      OPM_NORMAL  = 2'b00,
      OPM_NODRIVE = 2'b01,
      OPM_RAW     = 2'b10,
      OPM_RSVD    = 2'b11
   } opmode_e;

   typedef enum logic [1:0] {
      SPD_HIGH    = 2'b00,
      SPD_FULL    = 2'b01,
      SPD_LOW     = 2'b10,
      SPD_LOWFAST = 2'b11
   } speed_e;

   typedef struct packed {
      logic [1:0] opmode;
      logic [1:0] speed;
      logic       term;
   } utmi_mode_t;

   typedef enum logic [1:0] {
      TXS_IDLE = 2'b00,
      TXS_SEND = 2'b01,
      TXS_GAP  = 2'b10
   } tx_state_e;

endpackage

// File: rtl/utmi_tx_startup.sv
module utmi_tx_startup #(
   parameter int unsigned START_WAIT = 5
) (
   input  logic clk,
   input  logic rst,
   output logic start_done
);
   localparam int unsigned CNT_W = $clog2(START_WAIT + 1);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(START_WAIT);

   logic [CNT_W-1:0] edge_cnt;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         edge_cnt <= '0;
      end else if (edge_cnt != CNT_END) begin
         edge_cnt <= edge_cnt + 1'b1;
      end
   end

   assign start_done = (edge_cnt == CNT_END);

   // R2
   start_hold_chk: assert property (@(posedge clk) disable iff (rst)
      start_done |=> start_done);

endmodule

// File: rtl/utmi_tx_mode_ctl.sv
module utmi_tx_mode_ctl
   import utmi_tx_pkg::*;
#(
   parameter utmi_mode_t RESET_MODE = '{opmode: 2'b00, speed: 2'b01, term: 1'b1}
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       req_valid,
   input  utmi_mode_t req_mode,
   input  logic       apply,
   output logic       pending,
   output utmi_mode_t mode_q
);
   logic       req_ok;
   utmi_mode_t held_q;

   assign req_ok = req_valid && (req_mode.opmode != OPM_RSVD);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         pending <= 1'b0;
         held_q  <= RESET_MODE;
      end else if (req_ok) begin
         pending <= 1'b1;
         held_q  <= req_mode;
      end else if (apply) begin
         pending <= 1'b0;
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         mode_q <= RESET_MODE;
      end else if (apply) begin
         mode_q <= held_q;
      end
   end

   // R10
   no_rsvd_out_chk: assert property (@(posedge clk) disable iff (rst)
      mode_q.opmode != OPM_RSVD);

   // R10
   rsvd_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_mode.opmode == OPM_RSVD && !pending) |=> !pending);

   // R9
   held_mode_chk: assert property (@(posedge clk) disable iff (rst)
      !apply |=> $stable(mode_q));

endmodule

// File: rtl/utmi_tx_ctrl.sv
module utmi_tx_ctrl
   import utmi_tx_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned GAP_CYCLES = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_done,
   input  logic              mode_pending,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_valid,
   input  logic              s_last,
   input  logic              txready,
   output logic              s_ready,
   output logic              apply,
   output logic [DATA_W-1:0] data_q,
   output logic              txv_q,
   output logic              underrun_q
);
   tx_state_e state_q;
   logic      last_q;
   logic      gap_done;

   generate
      if (GAP_CYCLES == 1) begin : g_gap_single
         assign gap_done = 1'b1;
      end else begin : g_gap_count
         localparam int unsigned GW = $clog2(GAP_CYCLES);
         localparam logic [GW-1:0] GAP_END = GW'(GAP_CYCLES - 1);
         logic [GW-1:0] gap_cnt;
         always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
               gap_cnt <= '0;
            end else if (state_q != TXS_GAP) begin
               gap_cnt <= '0;
            end else if (gap_cnt != GAP_END) begin
               gap_cnt <= gap_cnt + 1'b1;
            end
         end
         assign gap_done = (gap_cnt == GAP_END);
      end
   endgenerate

   logic idle_take;
   logic send_take;

   assign apply     = (state_q == TXS_IDLE) && mode_pending;
   assign idle_take = (state_q == TXS_IDLE) && start_done && !mode_pending;
   assign send_take = (state_q == TXS_SEND) && txready && !last_q;
   assign s_ready   = idle_take || send_take;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state_q    <= TXS_IDLE;
         data_q     <= '0;
         last_q     <= 1'b0;
         txv_q      <= 1'b0;
         underrun_q <= 1'b0;
      end else begin
         underrun_q <= 1'b0;
         unique case (state_q)
            TXS_IDLE: begin
               if (idle_take && s_valid) begin
                  data_q  <= s_data;
                  last_q  <= s_last;
                  txv_q   <= 1'b1;
                  state_q <= TXS_SEND;
               end
            end
            TXS_SEND: begin
               if (txready) begin
                  if (last_q) begin
                     txv_q   <= 1'b0;
                     state_q <= TXS_GAP;
                  end else if (s_valid) begin
                     data_q <= s_data;
                     last_q <= s_last;
                  end else begin
                     txv_q      <= 1'b0;
                     underrun_q <= 1'b1;
                     state_q    <= TXS_GAP;
                  end
               end
            end
            TXS_GAP: begin
               if (gap_done) begin
                  state_q <= TXS_IDLE;
               end
            end
            default: state_q <= TXS_IDLE;
         endcase
      end
   end

   // R4
   hold_byte_chk: assert property (@(posedge clk) disable iff (rst)
      (txv_q && !txready) |=> (txv_q && $stable(data_q)));

   // R6
   close_after_last_chk: assert property (@(posedge clk) disable iff (rst)
      (txv_q && txready && last_q) |=> !txv_q);

   // R7
   min_gap_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(txv_q) |=> !txv_q);

   // R11
   underrun_close_chk: assert property (@(posedge clk) disable iff (rst)
      underrun_q |-> !txv_q);

   // R11
   underrun_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      underrun_q |=> !underrun_q);

   // R2
   no_early_open_chk: assert property (@(posedge clk) disable iff (rst)
      (!txv_q && !start_done) |=> !txv_q);

endmodule

// File: rtl/utmi_tx_link.sv
module utmi_tx_link
   import utmi_tx_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned START_WAIT = 5,
   parameter int unsigned GAP_CYCLES = 1,
   parameter logic [1:0]  RST_OPMODE = 2'b00,
   parameter logic [1:0]  RST_SPEED  = 2'b01,
   parameter logic        RST_TERM   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_valid,
   input  logic              s_last,
   output logic              s_ready,
   input  logic              mode_req_valid,
   input  logic [1:0]        mode_req_opmode,
   input  logic [1:0]        mode_req_speed,
   input  logic              mode_req_term,
   output logic [DATA_W-1:0] utmi_data,
   output logic              utmi_txvalid,
   input  logic              utmi_txready,
   output logic [1:0]        utmi_opmode,
   output logic [1:0]        utmi_xcvrsel,
   output logic              utmi_termsel,
   output logic              tx_underrun
);
   localparam utmi_mode_t RESET_MODE = '{opmode: RST_OPMODE, speed: RST_SPEED, term: RST_TERM};

   generate
      if (DATA_W != 8 && DATA_W != 16) begin : g_bad_width
         $error("utmi_tx_link: DATA_W must be 8 or 16");
      end
      if (START_WAIT < 5) begin : g_bad_wait
         $error("utmi_tx_link: START_WAIT must be at least 5");
      end
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("utmi_tx_link: GAP_CYCLES must be at least 1");
      end
      if (RST_OPMODE == 2'b11) begin : g_bad_opmode
         $error("utmi_tx_link: reserved operating mode as reset value");
      end
   endgenerate

   logic       start_done;
   logic       mode_pending;
   logic       mode_apply;
   utmi_mode_t req_mode;
   utmi_mode_t cur_mode;

   assign req_mode = '{opmode: mode_req_opmode, speed: mode_req_speed, term: mode_req_term};

   utmi_tx_startup #(
      .START_WAIT(START_WAIT)
   ) u_startup (
      .clk        (clk),
      .rst        (rst),
      .start_done (start_done)
   );

   utmi_tx_mode_ctl #(
      .RESET_MODE(RESET_MODE)
   ) u_mode (
      .clk       (clk),
      .rst       (rst),
      .req_valid (mode_req_valid),
      .req_mode  (req_mode),
      .apply     (mode_apply),
      .pending   (mode_pending),
      .mode_q    (cur_mode)
   );

   utmi_tx_ctrl #(
      .DATA_W     (DATA_W),
      .GAP_CYCLES (GAP_CYCLES)
   ) u_ctrl (
      .clk          (clk),
      .rst          (rst),
      .start_done   (start_done),
      .mode_pending (mode_pending),
      .s_data       (s_data),
      .s_valid      (s_valid),
      .s_last       (s_last),
      .txready      (utmi_txready),
      .s_ready      (s_ready),
      .apply        (mode_apply),
      .data_q       (utmi_data),
      .txv_q        (utmi_txvalid),
      .underrun_q   (tx_underrun)
   );

   assign utmi_opmode  = cur_mode.opmode;
   assign utmi_xcvrsel = cur_mode.speed;
   assign utmi_termsel = cur_mode.term;

   // R8
   mode_edge_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(utmi_txvalid) || $fell(utmi_txvalid)) |->
         ($stable(utmi_opmode) && $stable(utmi_xcvrsel) && $stable(utmi_termsel)));

   // R8
   mode_busy_chk: assert property (@(posedge clk) disable iff (rst)
      utmi_txvalid |=> ($stable(utmi_opmode) && $stable(utmi_xcvrsel) && $stable(utmi_termsel)));

endmodule

// File: tb/utmi_tx_link_test.sv
module utmi_tx_link_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] s_data;
   logic       s_valid, s_last, s_ready;
   logic       mode_req_valid = 1'b0;
   logic [1:0] mode_req_opmode = 2'b00;
   logic [1:0] mode_req_speed = 2'b00;
   logic       mode_req_term = 1'b0;
   logic [7:0] utmi_data;
   logic       utmi_txvalid, utmi_txready;
   logic [1:0] utmi_opmode, utmi_xcvrsel;
   logic       utmi_termsel, tx_underrun;

   always #4 clk = ~clk;

   utmi_tx_link uut (
      .clk(clk), .rst(rst),
      .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
      .mode_req_valid(mode_req_valid), .mode_req_opmode(mode_req_opmode),
      .mode_req_speed(mode_req_speed), .mode_req_term(mode_req_term),
      .utmi_data(utmi_data), .utmi_txvalid(utmi_txvalid), .utmi_txready(utmi_txready),
      .utmi_opmode(utmi_opmode), .utmi_xcvrsel(utmi_xcvrsel), .utmi_termsel(utmi_termsel),
      .tx_underrun(tx_underrun)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // source model
   logic [7:0] src_mem [0:31];
   logic       src_lastm [0:31];
   int         src_len = 0;
   int         src_stall = -1;
   bit         src_active = 1'b0;
   int         pkt_gen = 0;
   int         seen_gen = 0;
   int         src_idx = 0;
   int         cyc = 0;
   int         rdy_mode = 0;

   assign s_valid = src_active && (seen_gen == pkt_gen) && (src_idx < src_len) && (src_idx != src_stall);
   assign s_data  = (src_idx < 32) ? src_mem[src_idx] : 8'h00;
   assign s_last  = (src_idx < 32) ? src_lastm[src_idx] : 1'b0;
   assign utmi_txready = (rdy_mode == 0) ? 1'b1 :
                         (rdy_mode == 1) ? cyc[0] :
                         (rdy_mode == 2) ? (cyc % 3 == 0) : 1'b0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (seen_gen != pkt_gen) begin
         seen_gen <= pkt_gen;
         src_idx  <= 0;
      end else if (s_valid && s_ready) begin
         src_idx <= src_idx + 1;
      end
   end

   // PHY-side monitor
   logic [7:0] rx [0:63];
   int rx_cnt = 0, rx_base = 0;
   int hold_err = 0, hold_seen = 0, fall_err = 0, gap_err = 0, mode_err = 0;
   int rises = 0, ur_cnt = 0;
   bit prev_hold = 0, was_last = 0, txv_p1 = 0, txv_p2 = 0;
   logic [7:0] prev_data = 8'h00;
   logic [4:0] mode_p = 5'h00;

   always @(posedge clk) begin
      if (!rst) begin
         if (prev_hold) begin
            hold_seen <= hold_seen + 1;
            if (!utmi_txvalid || utmi_data != prev_data) hold_err <= hold_err + 1;
         end
         if (was_last && utmi_txvalid) fall_err <= fall_err + 1;
         if (txv_p2 && !txv_p1 && utmi_txvalid) gap_err <= gap_err + 1;
         if ({utmi_opmode, utmi_xcvrsel, utmi_termsel} != mode_p &&
             (utmi_txvalid || txv_p1)) mode_err <= mode_err + 1;
         if (utmi_txvalid && !txv_p1) rises <= rises + 1;
         if (tx_underrun) ur_cnt <= ur_cnt + 1;
         was_last <= 1'b0;
         if (utmi_txvalid && utmi_txready) begin
            if (rx_cnt < 64) rx[rx_cnt] <= utmi_data;
            rx_cnt   <= rx_cnt + 1;
            if (rx_cnt - rx_base >= 0 && rx_cnt - rx_base < 32)
               was_last <= src_lastm[rx_cnt - rx_base];
         end
      end
      prev_hold <= !rst && utmi_txvalid && !utmi_txready;
      prev_data <= utmi_data;
      txv_p2    <= txv_p1;
      txv_p1    <= utmi_txvalid;
      mode_p    <= {utmi_opmode, utmi_xcvrsel, utmi_termsel};
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load_stream(input int len, input int stall, input int last_a, input int last_b, input int seed);
      @(negedge clk);
      src_active = 1'b0;
      for (int i = 0; i < 32; i++) begin
         src_mem[i]   = 8'((seed * 37 + i * 13 + 5) & 8'hff);
         src_lastm[i] = (i == last_a) || (i == last_b);
      end
      src_len   = len;
      src_stall = stall;
      rx_base   = rx_cnt;
      pkt_gen   = pkt_gen + 1;
      src_active = 1'b1;
   endtask

   task automatic wait_drain(input int len);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (rx_cnt - rx_base >= len && !utmi_txvalid) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic check_bytes(input int len, input string req);
      bit ok = (rx_cnt - rx_base == len);
      for (int i = 0; i < len; i++)
         if (rx[rx_base + i] != src_mem[i]) ok = 1'b0;
      check(ok, req, rx_cnt - rx_base, len);
   endtask

   task automatic send_req(input logic [1:0] op, input logic [1:0] sp, input logic tm);
      @(negedge clk);
      mode_req_valid = 1'b1; mode_req_opmode = op; mode_req_speed = sp; mode_req_term = tm;
      @(negedge clk);
      mode_req_valid = 1'b0;
   endtask

   task automatic t_reset_and_startup();
      rst = 1'b1;
      load_stream(1, -1, 0, -1, 1);
      rdy_mode = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!utmi_txvalid && !tx_underrun && !s_ready, "R1", {utmi_txvalid, tx_underrun, s_ready}, 0);
      check(utmi_opmode == 2'b00 && utmi_xcvrsel == 2'b01 && utmi_termsel == 1'b1, "R1",
            {utmi_opmode, utmi_xcvrsel, utmi_termsel}, 5'b00011);
      rst = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      // R2 not yet open after 5 edges
      check(!utmi_txvalid, "R2", utmi_txvalid, 0);
      @(negedge clk);
      // R2 open on edge 6, R3 first byte on bus
      check(utmi_txvalid, "R2", utmi_txvalid, 1);
      check(utmi_data == src_mem[0], "R3", utmi_data, src_mem[0]);
      wait_drain(1);
      check_bytes(1, "R3");
   endtask

   task automatic t_stream_fast();
      int fe = fall_err;
      rdy_mode = 0;
      load_stream(5, -1, 4, -1, 2);
      wait_drain(5);
      // R5 back-to-back bytes delivered in order
      check_bytes(5, "R5");
      // R6 closed right after last
      check(fall_err == fe, "R6", fall_err - fe, 0);
   endtask

   task automatic t_stream_slow();
      int he = hold_err, hs = hold_seen;
      rdy_mode = 2;
      load_stream(6, -1, 5, -1, 3);
      wait_drain(6);
      check_bytes(6, "R3");
      // R4 byte held while not acknowledged
      check(hold_err == he, "R4", hold_err - he, 0);
      check(hold_seen > hs, "R4", hold_seen - hs, 1);
   endtask

   task automatic t_back_to_back();
      int r0 = rises, ge = gap_err, fe = fall_err;
      rdy_mode = 1;
      load_stream(5, -1, 2, 4, 4);
      wait_drain(5);
      check_bytes(5, "R5");
      check(rises - r0 == 2, "R6", rises - r0, 2);
      // R7 idle gap between packets
      check(gap_err == ge, "R7", gap_err - ge, 0);
      check(fall_err == fe, "R6", fall_err - fe, 0);
   endtask

   task automatic t_mode_idle();
      rdy_mode = 0;
      src_active = 1'b0;
      send_req(2'b10, 2'b00, 1'b0);
      repeat (2) @(negedge clk);
      // R9 idle request applied
      check(utmi_opmode == 2'b10 && utmi_xcvrsel == 2'b00 && utmi_termsel == 1'b0, "R9",
            {utmi_opmode, utmi_xcvrsel, utmi_termsel}, 5'b10000);
      send_req(2'b11, 2'b10, 1'b1);
      repeat (4) @(negedge clk);
      // R10 reserved opmode request dropped
      check(utmi_opmode == 2'b10 && utmi_xcvrsel == 2'b00 && utmi_termsel == 1'b0, "R10",
            {utmi_opmode, utmi_xcvrsel, utmi_termsel}, 5'b10000);
   endtask

   task automatic t_mode_deferred();
      int me = mode_err;
      bit held = 1'b1;
      rdy_mode = 2;
      load_stream(8, -1, 7, -1, 5);
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (utmi_txvalid) break;
      end
      send_req(2'b01, 2'b11, 1'b1);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (utmi_txvalid && utmi_opmode != 2'b10) held = 1'b0;
      end
      // R9 held back during packet
      check(held && utmi_txvalid, "R9", utmi_opmode, 2'b10);
      wait_drain(8);
      check_bytes(8, "R3");
      check(utmi_opmode == 2'b01 && utmi_xcvrsel == 2'b11 && utmi_termsel == 1'b1, "R9",
            {utmi_opmode, utmi_xcvrsel, utmi_termsel}, 5'b01111);
      // R8 no mode change on a txvalid edge or while high
      check(mode_err == me, "R8", mode_err - me, 0);
   endtask

   task automatic t_underrun();
      int u0 = ur_cnt;
      rdy_mode = 0;
      load_stream(4, 2, 3, -1, 6);
      repeat (12) @(negedge clk);
      src_active = 1'b0;
      // R11 packet closed, flag one cycle, two bytes sent
      check(ur_cnt - u0 == 1, "R11", ur_cnt - u0, 1);
      check(rx_cnt - rx_base == 2, "R11", rx_cnt - rx_base, 2);
      check(!utmi_txvalid, "R11", utmi_txvalid, 0);
   endtask

   task automatic t_ready_idle();
      int r0 = rises, c0 = rx_cnt;
      src_active = 1'b0;
      rdy_mode = 0;
      repeat (10) @(negedge clk);
      // R12 acknowledge with no packet does nothing
      check(rises == r0 && rx_cnt == c0 && !utmi_txvalid, "R12", rises - r0, 0);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) begin src_mem[i] = 8'h00; src_lastm[i] = 1'b0; end
      t_reset_and_startup();
      t_stream_fast();
      t_stream_slow();
      t_back_to_back();
      t_mode_idle();
      t_mode_deferred();
      t_underrun();
      t_ready_idle();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule